// File: doc/BRIEF.md
# Indexed ADC Configuration Register Bank

This block stores the per-conversion setup words used by an ADC sequencer. There are thirty-two slots, each sixteen bits wide. A host reaches all of them through a single data port and a slot pointer. It can set the pointer directly, and then issue a run of writes. Each accepted write fills the slot under the pointer, and the pointer then steps forward by one. Consecutive writes therefore populate consecutive slots without the host touching the pointer again.

The sequencer has its own read port. It picks any slot and gets the raw word, the word split into its fields, and a flag that marks a channel code as illegal for the slot's input mode. The same illegality flag is also available for every slot at once, as a vector. While the converter reports busy, the bank refuses host writes. Reads stay available at all times.

Top module: `adcCfgBank`

## Requirements
- R1: A host write (hostWrEn=1) is accepted only when cfgMode=1, avgMode=0 and convBusy=0. Any other write changes neither a slot nor the pointer.
- R2: Each accepted write stores into the slot at curIdx. The pointer then advances by one on the same clock edge, and it wraps from 31 to 0.
- R3: idxLoad=1 puts idxLoadVal into curIdx on the next edge, and it wins over the auto-advance. A write accepted in that same cycle still lands in the slot at the old pointer.
- R4: While convBusy=1, host writes are refused and the pointer holds. All read outputs keep working and return unchanged contents.
- R5: Bit 15 of every slot always reads 0, whatever value was written to it.
- R6: An active-low reset clears all 32 slots to 16'h0000 and the pointer to 0.
- R7: The sequencer port decodes the slot selected by seqSel into these fields: gain = bits 14:13, alternate result location = bits 12:8, acquisition extension = bit 7, left alignment = bit 6, differential = bit 5, channel = bits 4:0.
- R8: A channel code is illegal when it lies in 20..24 or 26..31 (in either mode), or in 8..15 with the differential bit set. All other codes are legal. chanBad[i] flags slot i, and seqChanBad flags the slot selected by seqSel.
- R9: hostRdData returns the whole word of the slot at curIdx, and curIdx shows the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgMode | input | 1 | Configuration mode select |
| avgMode | input | 1 | Averaging mode; blocks slot writes when high |
| convBusy | input | 1 | Converter busy; blocks slot writes when high |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 16 | Host write data |
| idxLoad | input | 1 | Load strobe for the slot pointer |
| idxLoadVal | input | 5 | New pointer value |
| curIdx | output | 5 | Current slot pointer |
| hostRdData | output | 16 | Word of the slot at curIdx |
| seqSel | input | 5 | Sequencer slot select |
| seqWord | output | 16 | Raw word of the selected slot |
| seqGain | output | 2 | Gain field |
| seqAltLoc | output | 5 | Alternate result location field |
| seqAcqExt | output | 1 | Acquisition extension enable |
| seqAlignLeft | output | 1 | Left-alignment select |
| seqDiff | output | 1 | Differential mode |
| seqChan | output | 5 | Channel code |
| seqChanBad | output | 1 | Selected slot holds an illegal channel |
| chanBad | output | 32 | Per-slot illegal-channel flags |

## Verification
The assertions assume three things about the inputs. The busy input does not change in the middle of a cycle. The pointer load and the write strobe are single-cycle pulses. The values on idxLoadVal and seqSel are settled before each sampling edge. The stimulus drives every input on the falling clock edge and holds it for at least one full cycle. It loads the pointer only between write bursts, except in one deliberate case where a load and a write share a cycle. It sweeps all 32 channel codes in both input modes, so every slot is written and read back through both the sequencer port and the illegal-channel vector.

// File: rtl/adcCfgPkg.sv
package adcCfgPkg;
  localparam int WORD_W    = 16;
  localparam int CHAN_W    = 5;
  localparam int RSVD_BIT  = 15;
  localparam int GAIN_HI   = 14;
  localparam int GAIN_LO   = 13;
  localparam int ALT_HI    = 12;
  localparam int ALT_LO    = 8;
  localparam int ACQ_BIT   = 7;
  localparam int ALIGN_BIT = 6;
  localparam int DIFF_BIT  = 5;
  localparam int CHAN_HI   = 4;

  typedef struct packed {
    logic wrSlot;
    logic advIdx;
    logic loadIdx;
  } cfgStrobe_t;

  function automatic logic chanIllegal(input logic [CHAN_W-1:0] ch, input logic diff);
    logic commonBad;
    logic diffBad;
    commonBad = (ch >= 5'd20) && (ch != 5'd25);
    diffBad   = diff && (ch >= 5'd8) && (ch <= 5'd15);
    return commonBad || diffBad;
  endfunction
endpackage

// File: rtl/adcCfgCtrl.sv
module adcCfgCtrl
  import adcCfgPkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic             cfgMode,
  input  logic             avgMode,
  input  logic             convBusy,
  input  logic             idxLoad,
  input  logic [IDX_W-1:0] idxLoadVal,
  output cfgStrobe_t       strb,
  output logic [IDX_W-1:0] curIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  always_comb begin
    strb.wrSlot  = hostWrEn && cfgMode && !avgMode && !convBusy;
    strb.loadIdx = idxLoad;
    strb.advIdx  = strb.wrSlot && !idxLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx <= '0;
    end else if (strb.loadIdx) begin
      curIdx <= idxLoadVal;
    end else if (strb.advIdx) begin
      curIdx <= (curIdx == LAST_IDX) ? '0 : curIdx + 1'b1;
    end
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn && cfgMode && !avgMode && !convBusy && !idxLoad |=>
      curIdx == (($past(curIdx) == LAST_IDX) ? '0 : $past(curIdx) + 1'b1)); // R2
  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    idxLoad |=> curIdx == $past(idxLoadVal)); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    convBusy && !idxLoad |=> $stable(curIdx)); // R4
  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgMode || avgMode) && !idxLoad |=> $stable(curIdx)); // R1
endmodule

// File: rtl/adcCfgData.sv
module adcCfgData
  import adcCfgPkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [WORD_W-1:0] wrData,
  input  logic [IDX_W-1:0]  seqSel,
  output logic [WORD_W-1:0] hostRdData,
  output logic [WORD_W-1:0] seqWord,
  output logic [1:0]        seqGain,
  output logic [4:0]        seqAltLoc,
  output logic              seqAcqExt,
  output logic              seqAlignLeft,
  output logic              seqDiff,
  output logic [CHAN_W-1:0] seqChan,
  output logic              seqChanBad,
  output logic [NUM_SLOTS-1:0] chanBad
);
  logic [WORD_W-1:0] slotMem [NUM_SLOTS];

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotMem[gi] <= '0;
      end else if (strb.wrSlot && (wrIdx == IDX_W'(gi))) begin
        slotMem[gi] <= {1'b0, wrData[RSVD_BIT-1:0]};
      end
    end

    always_comb chanBad[gi] = chanIllegal(slotMem[gi][CHAN_HI:0], slotMem[gi][DIFF_BIT]);

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.wrSlot && (wrIdx == IDX_W'(gi))) |=> $stable(slotMem[gi])); // R1
  end

  always_comb begin
    hostRdData   = slotMem[wrIdx];
    seqWord      = slotMem[seqSel];
    seqGain      = seqWord[GAIN_HI:GAIN_LO];
    seqAltLoc    = seqWord[ALT_HI:ALT_LO];
    seqAcqExt    = seqWord[ACQ_BIT];
    seqAlignLeft = seqWord[ALIGN_BIT];
    seqDiff      = seqWord[DIFF_BIT];
    seqChan      = seqWord[CHAN_HI:0];
    seqChanBad   = chanBad[seqSel];
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !seqWord[RSVD_BIT] && !hostRdData[RSVD_BIT]); // R5
  AST_BAD_COMMON: assert property (@(posedge clk) disable iff (!rstN)
    (seqChan >= 5'd20) && (seqChan != 5'd25) |-> seqChanBad); // R8
  AST_GOOD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (seqChan <= 5'd7) || ((seqChan >= 5'd16) && (seqChan <= 5'd19)) || (seqChan == 5'd25)
      |-> !seqChanBad); // R8
endmodule

// File: rtl/adcCfgBank.sv
module adcCfgBank
  import adcCfgPkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgMode,
  input  logic                 avgMode,
  input  logic                 convBusy,
  input  logic                 hostWrEn,
  input  logic [WORD_W-1:0]    hostWrData,
  input  logic                 idxLoad,
  input  logic [IDX_W-1:0]     idxLoadVal,
  output logic [IDX_W-1:0]     curIdx,
  output logic [WORD_W-1:0]    hostRdData,
  input  logic [IDX_W-1:0]     seqSel,
  output logic [WORD_W-1:0]    seqWord,
  output logic [1:0]           seqGain,
  output logic [4:0]           seqAltLoc,
  output logic                 seqAcqExt,
  output logic                 seqAlignLeft,
  output logic                 seqDiff,
  output logic [CHAN_W-1:0]    seqChan,
  output logic                 seqChanBad,
  output logic [NUM_SLOTS-1:0] chanBad
);
  cfgStrobe_t strb;

  adcCfgCtrl #(.NUM_SLOTS(NUM_SLOTS)) uCtrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .cfgMode(cfgMode),
    .avgMode(avgMode), .convBusy(convBusy), .idxLoad(idxLoad),
    .idxLoadVal(idxLoadVal), .strb(strb), .curIdx(curIdx)
  );

  adcCfgData #(.NUM_SLOTS(NUM_SLOTS)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(curIdx), .wrData(hostWrData),
    .seqSel(seqSel), .hostRdData(hostRdData), .seqWord(seqWord),
    .seqGain(seqGain), .seqAltLoc(seqAltLoc), .seqAcqExt(seqAcqExt),
    .seqAlignLeft(seqAlignLeft), .seqDiff(seqDiff), .seqChan(seqChan),
    .seqChanBad(seqChanBad), .chanBad(chanBad)
  );

  AST_BUSY_RD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    convBusy && !idxLoad |=> $stable(hostRdData)); // R4
endmodule

// File: tb/tb_adcCfgBank.sv
module tb_adcCfgBank;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgMode = 1'b0, avgMode = 1'b0, convBusy = 1'b0;
  logic hostWrEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic idxLoad = 1'b0;
  logic [4:0] idxLoadVal = '0;
  logic [4:0] curIdx;
  logic [15:0] hostRdData;
  logic [4:0] seqSel = '0;
  logic [15:0] seqWord;
  logic [1:0] seqGain;
  logic [4:0] seqAltLoc;
  logic seqAcqExt, seqAlignLeft, seqDiff, seqChanBad;
  logic [4:0] seqChan;
  logic [31:0] chanBad;

  int checks = 0;
  int errors = 0;
  logic [15:0] mdl [NS];
  int mIdx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcCfgBank dut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .avgMode(avgMode), .convBusy(convBusy),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .idxLoad(idxLoad), .idxLoadVal(idxLoadVal),
    .curIdx(curIdx), .hostRdData(hostRdData), .seqSel(seqSel), .seqWord(seqWord),
    .seqGain(seqGain), .seqAltLoc(seqAltLoc), .seqAcqExt(seqAcqExt),
    .seqAlignLeft(seqAlignLeft), .seqDiff(seqDiff), .seqChan(seqChan),
    .seqChanBad(seqChanBad), .chanBad(chanBad)
  );

  function automatic logic expBad(input logic [15:0] w);
    int c;
    c = int'(w[4:0]);
    return ((c >= 20) && (c != 25)) || (w[5] && (c >= 8) && (c <= 15));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostWr(input logic [15:0] d);
    @(negedge clk);
    hostWrData = d;
    hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
    if (cfgMode && !avgMode && !convBusy) begin
      mdl[mIdx] = d & 16'h7fff;
      mIdx = (mIdx + 1) % NS;
    end
  endtask

  task automatic setIdx(input int v);
    @(negedge clk);
    idxLoad = 1'b1;
    idxLoadVal = 5'(v);
    @(negedge clk);
    idxLoad = 1'b0;
    mIdx = v;
  endtask

  task automatic checkAll(input string req);
    logic [31:0] expVec;
    expVec = '0;
    for (int i = 0; i < NS; i++) begin
      @(negedge clk);
      seqSel = 5'(i);
      #1;
      chk(seqWord == mdl[i], {req, " word"}, 32'(seqWord), 32'(mdl[i]));
      chk({seqGain, seqAltLoc, seqAcqExt, seqAlignLeft, seqDiff, seqChan} == mdl[i][14:0],
          "R7 fields", 32'({seqGain, seqAltLoc, seqAcqExt, seqAlignLeft, seqDiff, seqChan}),
          32'(mdl[i][14:0]));
      chk(seqChanBad == expBad(mdl[i]), "R8 seqChanBad", 32'(seqChanBad), 32'(expBad(mdl[i])));
      expVec[i] = expBad(mdl[i]);
    end
    chk(chanBad == expVec, "R8 chanBad vector", chanBad, expVec);
    chk(curIdx == 5'(mIdx), "R9 curIdx", 32'(curIdx), 32'(mIdx));
    chk(hostRdData == mdl[mIdx], "R9 hostRdData", 32'(hostRdData), 32'(mdl[mIdx]));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    for (int i = 0; i < NS; i++) mdl[i] = '0;
    mIdx = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  bit done = 0;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    doReset();
    // R6 reset state
    checkAll("R6");

    cfgMode = 1'b1;
    for (int i = 0; i < NS; i++) hostWr(16'(i * 16'h1357) ^ 16'hA5A5 ^ ((i % 2 == 1) ? 16'h8000 : 16'h0000));
    // R2 wrap after 32 writes, R5 bit 15 masked
    chk(curIdx == 5'd0, "R2 wrap", 32'(curIdx), 32'd0);
    checkAll("R5 R2");

    setIdx(17);
    chk(curIdx == 5'd17, "R3 load", 32'(curIdx), 32'd17);
    chk(hostRdData == mdl[17], "R9 read at pointer", 32'(hostRdData), 32'(mdl[17]));

    // R4 busy blocks writes and pointer advance
    convBusy = 1'b1;
    held = hostRdData;
    hostWr(16'h1234); hostWr(16'h4321); hostWr(16'h7777);
    chk(curIdx == 5'd17, "R4 pointer held", 32'(curIdx), 32'd17);
    chk(hostRdData == held, "R4 read stable", 32'(hostRdData), 32'(held));
    checkAll("R4");
    convBusy = 1'b0;

    // R1 mode gating
    cfgMode = 1'b0; hostWr(16'h0F0F);
    cfgMode = 1'b1; avgMode = 1'b1; hostWr(16'h7070);
    avgMode = 1'b0;
    chk(curIdx == 5'd17, "R1 pointer held", 32'(curIdx), 32'd17);
    checkAll("R1");

    // R3 load and write in the same cycle
    setIdx(4);
    @(negedge clk);
    idxLoad = 1'b1; idxLoadVal = 5'd9; hostWrData = 16'h2A55; hostWrEn = 1'b1;
    @(negedge clk);
    idxLoad = 1'b0; hostWrEn = 1'b0;
    mdl[4] = 16'h2A55; mIdx = 9;
    chk(curIdx == 5'd9, "R3 load priority", 32'(curIdx), 32'd9);
    checkAll("R3");

    // R8 full channel sweep in both modes
    for (int d = 0; d < 2; d++) begin
      setIdx(0);
      for (int c = 0; c < NS; c++) hostWr(16'((d << 5) | c | ((c % 4) << 13)));
      checkAll("R8 sweep");
    end

    // R6 reset mid-run
    @(negedge clk);
    doReset();
    checkAll("R6 rerun");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule